// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

The arbiter sits beside the fetch/execute control of a small single-issue core. It collects `N` interrupt sources and decides which one the core takes next. It then presents that source's entry address. Each source is fixed at build time as either a pulse-style source or a condition-style source. A pulse-style source has its rising edge caught in a sticky pending bit. A condition-style source asks for service only while its input is high. Every source has its own enable. A single global enable, owned by the arbiter, gates all of them.

The core reports its own events as single-cycle strobes:
- enable-all and disable-all instructions,
- return from a handler,
- each retired instruction.

The offer to the core is a valid/ready pair. `irq_req` is valid and `irq_take` is ready. The core raises `irq_take` only at an instruction boundary, so a multi-cycle instruction finishes before the handshake completes. While `irq_take` stays low, the core applies back-pressure and nothing is consumed. The offer may still change during that time: a higher-priority source can replace the vector, or a disable can withdraw the request. Only the vector and acknowledge that are present in the accepting cycle count. On acceptance the arbiter clears the global enable. It also pulses a one-hot acknowledge, which clears the winner's pending bit.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset the global enable, all pending bits and the request are zero.
- R2: Source `i` has vector index `i+1`, because index 0 is left for reset. The lowest enabled pending index wins. `irq_vec = base + 2*(i+1)`, so every slot is two words wide.
- R3: `vec_sel = 0` selects base 0. `vec_sel = 1` selects base `BOOT_BASE` (default 0x1C00).
- R4: A source can win only when its `src_en` bit is 1 and the global enable is 1.
- R5: When `irq_req && irq_take` in a cycle, `irq_ack` is one-hot on the winner in that cycle, and the global enable reads 0 from the next cycle.
- R6: `reti` or `gie_set` sets the global enable, and `gie_clr` clears it. If `gie_clr` arrives in the same cycle as a set, `gie_clr` wins.
- R7: A pulse-style pending bit stays set while its source or the global enable is off. It wins in priority order once both are on.
- R8: A pending bit clears when its source is accepted, or when a 1 is written to its `flag_clr` bit. A new rising edge in the same cycle keeps the bit set.
- R9: A condition-style source has no pending bit and requests only while its input is high.
- R10: After `reti` or `gie_set`, there is no request until a `retired` strobe arrives in a later cycle.
- R11: `gie_clr` suppresses `irq_req` in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N | Raw source lines |
| src_en | input | N | Per-source enables |
| flag_clr | input | N | Write-one-to-clear for pending bits |
| gie_set | input | 1 | Enable-all instruction strobe |
| gie_clr | input | 1 | Disable-all instruction strobe |
| reti | input | 1 | Return-from-handler strobe |
| retired | input | 1 | Instruction retired strobe |
| vec_sel | input | 1 | Vector base select (0 low, 1 boot) |
| irq_req | output | 1 | Interrupt offer (valid) |
| irq_take | input | 1 | Core accepts the offer (ready) |
| irq_vec | output | AW | Entry address of the current winner |
| irq_ack | output | N | One-hot acknowledge in the accepting cycle |
| gie | output | 1 | Global enable state |
| pend_flags | output | N | Pending bits (condition-style bits read 0) |

## Verification
The bench targets the one-instruction hold-off after an enable or a return. A design that lacked it would offer an interrupt before the following instruction had executed. It also targets a disable that arrives in the same cycle as a pending source, which a lax design would still let through. Pending bits held across a disabled window are checked for loss, and the edge-versus-clear race is checked for the wrong winner. A random phase compares every output, every cycle, with a bench model. That phase catches wrong priority order, a vector slot off by one, and a condition-style source that wrongly remembers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {BASE_LOW = 1'b0, BASE_BOOT = 1'b1} vec_base_e;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int N = 6,
  parameter logic [N-1:0] EDGE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] wr_clr,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flags,
  output logic [N-1:0] raw_pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q, flag_q, rise;
      assign rise = src_in[i] & ~prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= src_in[i];
          // a fresh edge beats a clear in the same cycle
          flag_q <= (flag_q & ~wr_clr[i] & ~ack[i]) | rise;
        end
      end
      assign flags[i]    = flag_q;
      assign raw_pend[i] = flag_q;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl  = wr_clr[i] ^ ack[i];
      assign flags[i]    = 1'b0;
      assign raw_pend[i] = src_in[i];
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any    = |req;
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gie_set,
  input  logic gie_clr,
  input  logic reti,
  input  logic retired,
  input  logic take,
  output logic gie,
  output logic holdoff
);
  logic arm;
  assign arm = (gie_set | reti) & ~gie_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      holdoff <= 1'b0;
    end else begin
      if (take || gie_clr) gie <= 1'b0;
      else if (gie_set || reti) gie <= 1'b1;

      if (take) holdoff <= 1'b0;
      else if (arm) holdoff <= 1'b1;
      else if (retired) holdoff <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqc_pkg::*;
#(
  parameter int N = 6,
  parameter int AW = 13,
  parameter logic [N-1:0] EDGE_MASK = 6'b001111,
  parameter logic [AW-1:0] BOOT_BASE = 13'h1C00,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_in,
  input  logic [N-1:0]  src_en,
  input  logic [N-1:0]  flag_clr,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          reti,
  input  logic          retired,
  input  logic          vec_sel,
  output logic          irq_req,
  input  logic          irq_take,
  output logic [AW-1:0] irq_vec,
  output logic [N-1:0]  irq_ack,
  output logic          gie,
  output logic [N-1:0]  pend_flags
);
  logic [N-1:0]  raw_pend, armed, win_oh;
  logic          any, holdoff, take;
  logic [IW-1:0] win_idx;
  logic [AW-1:0] base;
  vec_base_e     base_sel;

  irqc_flags #(.N(N), .EDGE_MASK(EDGE_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_clr(flag_clr),
    .ack(irq_ack), .flags(pend_flags), .raw_pend(raw_pend)
  );

  assign armed = raw_pend & src_en;

  irqc_prio #(.N(N)) u_prio (
    .req(armed), .any(any), .idx(win_idx), .onehot(win_oh)
  );

  irqc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .retired(retired), .take(take), .gie(gie), .holdoff(holdoff)
  );

  assign base_sel = vec_base_e'(vec_sel);
  always_comb begin
    case (base_sel)
      BASE_BOOT: base = BOOT_BASE;
      default:   base = '0;
    endcase
  end

  assign irq_req = gie & ~holdoff & ~gie_clr & any;
  assign take    = irq_req & irq_take;
  assign irq_ack = take ? win_oh : '0;
  assign irq_vec = base + ((AW'(win_idx) + AW'(1)) << 1);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N = 6,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie_set,
  input logic          gie_clr,
  input logic          reti,
  input logic          irq_req,
  input logic          irq_take,
  input logic [AW-1:0] irq_vec,
  input logic [N-1:0]  irq_ack,
  input logic          gie
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));
  assert_take_drops_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_take) |=> !gie);
  assert_ack_only_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) |-> (irq_req && irq_take));
  assert_req_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);
  assert_clr_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> !irq_req);
  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie);
  assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !(irq_req && irq_take)) |=> !irq_req);
  assert_vec_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !irq_vec[0]);
endmodule

bind irq_vector_arbiter irqc_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
  .irq_req(irq_req), .irq_take(irq_take), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .gie(gie)
);

// File: tb/tb_irq_vector_arbiter.sv
`timescale 1ns/1ps
module tb_irq_vector_arbiter;
  localparam int N = 6;
  localparam int AW = 13;
  localparam logic [N-1:0] EDGE = 6'b001111;
  localparam logic [AW-1:0] BOOT = 13'h1C00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0, src_en = '0, flag_clr = '0;
  logic gie_set = 0, gie_clr = 0, reti = 0, retired = 0, vec_sel = 0, irq_take = 0;
  logic irq_req, gie;
  logic [AW-1:0] irq_vec;
  logic [N-1:0] irq_ack, pend_flags;

  always #10 clk = ~clk;

  irq_vector_arbiter dut (.*);

  int checks = 0, fails = 0;
  logic m_gie = 0, m_hold = 0;
  logic [N-1:0] m_flag = '0, m_prev = '0;
  logic obs_req;
  logic [AW-1:0] obs_vec;
  logic [N-1:0] obs_ack;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input logic [N-1:0] e, input logic [N-1:0] w,
                      input logic gs, input logic gc, input logic ri, input logic rt,
                      input logic tk, input logic sl, input string tag);
    logic [N-1:0] pend, eack, rise;
    logic ereq, found;
    logic [AW-1:0] evec;
    @(negedge clk);
    src_in = s; src_en = e; flag_clr = w; gie_set = gs; gie_clr = gc;
    reti = ri; retired = rt; irq_take = tk; vec_sel = sl;
    #2;
    pend = (m_flag | (s & ~EDGE)) & e;
    found = 0; eack = '0; evec = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        found = 1;
        evec = (sl ? BOOT : AW'(0)) + AW'(2 * (i + 1));
        eack = N'(1) << i;
      end
    end
    ereq = m_gie && !m_hold && !gc && found;
    if (!(ereq && tk)) eack = '0;
    chk(32'(irq_req), 32'(ereq), {tag, " req"});
    if (ereq) chk(32'(irq_vec), 32'(evec), {tag, " vec"});
    chk(32'(irq_ack), 32'(eack), {tag, " ack"});
    chk(32'(gie), 32'(m_gie), {tag, " gie"});
    chk(32'(pend_flags), 32'(m_flag), {tag, " flags"});
    obs_req = irq_req; obs_vec = irq_vec; obs_ack = irq_ack;
    rise = s & ~m_prev & EDGE;
    m_flag = (m_flag & ~w & ~eack) | rise;
    m_prev = s;
    if (ereq && tk) begin m_gie = 0; m_hold = 0; end
    else begin
      if (gc) m_gie = 0; else if (gs || ri) m_gie = 1;
      if ((gs || ri) && !gc) m_hold = 1; else if (rt) m_hold = 0;
    end
    @(posedge clk);
  endtask

  localparam logic [N-1:0] ALL = '1;
  localparam logic [N-1:0] Z = '0;

  initial begin : main
    logic [31:0] r;
    r = $urandom(32'h5EED1);
    repeat (3) @(posedge clk);
    #5;
    chk(32'(gie), 0, "R1 gie"); chk(32'(pend_flags), 0, "R1 flags");
    chk(32'(irq_req), 0, "R1 req");
    @(negedge clk); rst_n = 1;
    // R6 enable, R10 hold-off
    step(Z, ALL, Z, 1,0,0,0,0,0, "R6");
    step(6'b000110, ALL, Z, 0,0,0,0,0,0, "R10");
    chk(32'(obs_req), 0, "R10 holdoff a");
    step(6'b000110, ALL, Z, 0,0,0,1,0,0, "R10");
    chk(32'(obs_req), 0, "R10 holdoff b");
    step(6'b000110, ALL, Z, 0,0,0,0,0,0, "R2");
    chk(32'(obs_vec), 4, "R2 vector of source 0-bit1");
    step(6'b000110, ALL, Z, 0,0,0,0,1,0, "R5");
    chk(32'(obs_ack), 32'(6'b000010), "R5 ack");
    #1; chk(32'(gie), 0, "R5 gie cleared"); chk(32'(pend_flags), 32'(6'b000100), "R8 ack clear");
    // R3 boot base
    step(6'b000100, ALL, Z, 0,0,1,0,0,0, "R6");
    step(6'b000100, ALL, Z, 0,0,0,1,0,0, "R10");
    step(6'b000100, ALL, Z, 0,0,0,0,0,1, "R3");
    chk(32'(obs_vec), 32'h1C06, "R3 boot vector");
    // R11 same-cycle disable
    step(6'b000100, ALL, Z, 0,1,0,0,1,0, "R11");
    chk(32'(obs_req), 0, "R11 suppressed");
    #1; chk(32'(gie), 0, "R6 cleared");
    step(6'b000100, ALL, Z, 1,1,0,0,0,0, "R6");
    #1; chk(32'(gie), 0, "R6 clear wins");
    // R4/R7 held while disabled
    step(6'b000100, ALL, Z, 1,0,0,0,0,0, "R6");
    step(6'b000100, Z, Z, 0,0,0,1,0,0, "R4");
    step(6'b000100, Z, Z, 0,0,0,0,0,0, "R4");
    chk(32'(obs_req), 0, "R4 source off");
    #1; chk(32'(pend_flags), 32'(6'b000100), "R7 held");
    step(6'b000100, ALL, Z, 0,0,0,0,0,0, "R7");
    chk(32'(obs_vec), 6, "R7 served later");
    // R8 write-one-clear
    step(6'b000100, ALL, 6'b000100, 0,0,0,0,0,0, "R8");
    #1; chk(32'(pend_flags), 0, "R8 sw clear");
    // R8 edge beats clear
    step(6'b000000, ALL, Z, 0,0,0,0,0,0, "R8");
    step(6'b000001, ALL, 6'b000001, 0,0,0,0,0,0, "R8");
    #1; chk(32'(pend_flags), 1, "R8 edge wins");
    step(6'b000001, ALL, 6'b000001, 0,0,0,0,0,0, "R8");
    // R9 level source
    step(6'b010000, ALL, Z, 0,0,0,0,0,0, "R9");
    chk(32'(obs_vec), 10, "R9 level vector");
    step(6'b000000, ALL, Z, 0,0,0,0,0,0, "R9");
    chk(32'(obs_req), 0, "R9 gone");
    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] s, e, w;
      s = N'($urandom);
      e = N'($urandom) | N'($urandom);
      w = (($urandom % 8) == 0) ? N'($urandom) : '0;
      step(s, e, w, ($urandom % 6) == 0, ($urandom % 12) == 0, ($urandom % 10) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0, "RND");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule